// File: doc/BRIEF.md
# Sliding-Window Complex Cumulant Estimator

This block takes a stream of complex baseband samples and keeps the second- and fourth-order moment sums of the most recent N samples. Each new sample adds its products to the sums. Once the window is full, the same update subtracts the products of the sample that leaves it. The samples themselves sit in a circular store whose slot is picked by one wrapping pointer. That slot serves as both the write slot for the arriving sample and the read slot for the leaving one. The sums are what the block reads back, and their storage does not grow with N.

The sums are divided by N with a shift of log2 N. From the averages the block forms four zero-mean cumulant features. C20 has real and imaginary parts and C21 is real. C40 has real and imaginary parts, and C42 is real. Second-order features are narrowed to 18-bit codes and fourth-order features to 24-bit codes. Every narrowing clips to the end codes instead of wrapping, and a flag reports whether any field of a vector was clipped. The first vector appears when the window first fills, and after that one appears every N/2 accepted samples. Each vector waits on an output valid/ready handshake, and input intake stops until the vector is taken.

A controller with four states runs the block. FILL collects the first window. SLIDE accepts samples into a full window. FORM latches the features from the updated sums. HOLD offers the vector. The transitions are:
- FILL goes to FORM on the Nth accepted sample.
- SLIDE goes to FORM on the N/2th sample after the last vector.
- FORM always goes to HOLD.
- HOLD goes to SLIDE when the vector is taken.
- Restart goes from any state to FILL, on clear or on a new window selection.

Top module: `cumulant_window_est`

## Requirements
- R1: A sample is taken on a clock edge where in_valid and in_ready are both high. in_ready is high in FILL and SLIDE only, so it is always low while out_valid is high.
- R2: win_sel code k selects N = 256·2^k for k = 0..4. Codes 5..7 select N = 4096.
- R3: After reset or a restart, the first vector is offered after exactly N accepted samples. No vector is offered before that.
- R4: After the first vector, a vector is offered every N/2 accepted samples. Each vector covers exactly the last N accepted samples, so older samples are evicted.
- R5: Take i and q as signed integers and let x = i + jq. With floor division, Ar = ⌊Σ(i²−q²)/N⌋, Ai = ⌊Σ2iq/N⌋ and B = ⌊Σ(i²+q²)/N⌋. Then c20_re = sat18(⌊Ar/2^10⌋), c20_im = sat18(⌊Ai/2^10⌋) and c21 = sat18(⌊B/2^10⌋). With 11 input fraction bits, this gives 12 fraction bits.
- R6: Let Dr = ⌊Σ Re(x⁴)/N⌋ and Di = ⌊Σ Im(x⁴)/N⌋. Then c40_re = sat24(⌊(Dr − 3(Ar²−Ai²))/2^28⌋) and c40_im = sat24(⌊(Di − 6·Ar·Ai)/2^28⌋). This gives 16 fraction bits.
- R7: Let E = ⌊Σ(i²+q²)²/N⌋. Then c42 = sat24(⌊(E − Ar² − Ai² − 2B²)/2^28⌋).
- R8: satW clips to 2^(W−1)−1 or −2^(W−1). out_sat is 1 exactly when at least one field of that vector was clipped.
- R9: While out_valid is high and out_ready is low, out_valid and every output field stay unchanged.
- R10: clr, or a change of win_sel, empties the window and zeroes all sums. It also drops any vector that has not been taken. A fresh first window then starts as in R3.
- R11: During reset, out_valid is 0 and in_ready is 1 once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous restart of collection |
| win_sel | input | 3 | Window length code (R2) |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample can be taken |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| out_valid | output | 1 | Feature vector offered |
| out_ready | input | 1 | Feature vector taken |
| c20_re | output | 18 | C20 real part |
| c20_im | output | 18 | C20 imaginary part |
| c21 | output | 18 | C21 |
| c40_re | output | 24 | C40 real part |
| c40_im | output | 24 | C40 imaginary part |
| c42 | output | 24 | C42 |
| out_sat | output | 1 | Some field of this vector was clipped |

## Verification
The assertions take for granted that clr and a win_sel change arrive only while no sample is offered. A sample offered in a restart cycle is dropped, and the window count would then not match what the source believes it sent. They also take for granted that win_sel stays steady between restarts. The stimulus changes win_sel or pulses clr only with in_valid low, and waits a cycle before offering samples again. Backpressure comes only from out_ready patterns, which the hold-stability check needs.

// File: rtl/cum_pkg.sv
package cum_pkg;
    typedef enum logic [1:0] {
        ST_FILL,
        ST_SLIDE,
        ST_FORM,
        ST_HOLD
    } cum_state_e;
endpackage

// File: rtl/cum_products.sv
module cum_products #(
    parameter int DW  = 16,
    parameter int P2W = 2*DW+1,
    parameter int P4W = 2*P2W
) (
    input  logic signed [DW-1:0]  smp_i,
    input  logic signed [DW-1:0]  smp_q,
    output logic signed [P2W-1:0] sq_re,
    output logic signed [P2W-1:0] sq_im,
    output logic signed [P2W-1:0] pw2,
    output logic signed [P4W-1:0] qd_re,
    output logic signed [P4W-1:0] qd_im,
    output logic signed [P4W-1:0] pw4
);
    logic signed [P2W-1:0] ie, qe, ii, qq, iq;
    logic signed [P4W-1:0] ae, be, me;

    always_comb begin
        ie    = P2W'(smp_i);
        qe    = P2W'(smp_q);
        ii    = ie * ie;
        qq    = qe * qe;
        iq    = ie * qe;
        sq_re = ii - qq;
        sq_im = iq <<< 1;
        pw2   = ii + qq;
        ae    = P4W'(sq_re);
        be    = P4W'(sq_im);
        me    = P4W'(pw2);
        qd_re = ae * ae - be * be;
        qd_im = (ae * be) <<< 1;
        pw4   = me * me;
    end
endmodule

// File: rtl/cum_ring.sv
module cum_ring #(
    parameter int DW      = 16,
    parameter int ADDR_W  = 12
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    slot,
    input  logic signed [DW-1:0] wr_i,
    input  logic signed [DW-1:0] wr_q,
    output logic signed [DW-1:0] rd_i,
    output logic signed [DW-1:0] rd_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [2*DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[slot] <= {wr_i, wr_q};
    end

    assign rd_i = store[slot][2*DW-1:DW];
    assign rd_q = store[slot][DW-1:0];
endmodule

// File: rtl/cum_sat.sv
module cum_sat #(
    parameter int IN_W  = 48,
    parameter int OUT_W = 18,
    parameter int SHIFT = 10
) (
    input  logic signed [IN_W-1:0]  val,
    output logic signed [OUT_W-1:0] code,
    output logic                    clip
);
    localparam logic signed [IN_W-1:0] TOP_V = IN_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
    localparam logic signed [IN_W-1:0] BOT_V = -TOP_V - IN_W'(1);

    logic signed [IN_W-1:0] scaled;

    always_comb begin
        scaled = val >>> SHIFT;
        if (scaled > TOP_V) begin
            code = OUT_W'(TOP_V);
            clip = 1'b1;
        end else if (scaled < BOT_V) begin
            code = OUT_W'(BOT_V);
            clip = 1'b1;
        end else begin
            code = OUT_W'(scaled);
            clip = 1'b0;
        end
        // R8: a clipped field sits on one of the two end codes
        assert_clip_end_code_R8: assert (!clip || code == OUT_W'(TOP_V) || code == OUT_W'(BOT_V));
    end
endmodule

// File: rtl/cum_former.sv
module cum_former #(
    parameter int DW      = 16,
    parameter int MAX_LOG = 12,
    parameter int IN_FRAC = 11,
    parameter int O2W     = 18,
    parameter int F2      = 12,
    parameter int O4W     = 24,
    parameter int F4      = 16,
    parameter int LW      = 4,
    parameter int S2W     = 2*DW+1+MAX_LOG,
    parameter int S4W     = 2*(2*DW+1)+MAX_LOG
) (
    input  logic [LW-1:0]         log_n,
    input  logic signed [S2W-1:0] s20_re,
    input  logic signed [S2W-1:0] s20_im,
    input  logic signed [S2W-1:0] s21,
    input  logic signed [S4W-1:0] s40_re,
    input  logic signed [S4W-1:0] s40_im,
    input  logic signed [S4W-1:0] s42,
    output logic signed [O2W-1:0] f20_re,
    output logic signed [O2W-1:0] f20_im,
    output logic signed [O2W-1:0] f21,
    output logic signed [O4W-1:0] f40_re,
    output logic signed [O4W-1:0] f40_im,
    output logic signed [O4W-1:0] f42,
    output logic                  any_clip
);
    localparam int CW  = 2*S2W + 3;
    localparam int SH2 = 2*IN_FRAC - F2;
    localparam int SH4 = 4*IN_FRAC - F4;

    logic signed [S2W-1:0] a_r, a_i, b_m;
    logic signed [S4W-1:0] d_r, d_i, e_m;
    logic signed [CW-1:0]  ar_w, ai_w, b_w, ar2, ai2, arai, b2, dif;
    logic signed [CW-1:0]  k40r, k40i, k42;
    logic [5:0]            clips;

    always_comb begin
        a_r  = s20_re >>> log_n;
        a_i  = s20_im >>> log_n;
        b_m  = s21    >>> log_n;
        d_r  = s40_re >>> log_n;
        d_i  = s40_im >>> log_n;
        e_m  = s42    >>> log_n;
        ar_w = CW'(a_r);
        ai_w = CW'(a_i);
        b_w  = CW'(b_m);
        ar2  = ar_w * ar_w;
        ai2  = ai_w * ai_w;
        arai = ar_w * ai_w;
        b2   = b_w * b_w;
        dif  = ar2 - ai2;
        k40r = CW'(d_r) - dif - (dif <<< 1);
        k40i = CW'(d_i) - (arai <<< 1) - (arai <<< 2);
        k42  = CW'(e_m) - ar2 - ai2 - (b2 <<< 1);
    end

    cum_sat #(.IN_W(S2W), .OUT_W(O2W), .SHIFT(SH2)) u_sat20r (.val(a_r),  .code(f20_re), .clip(clips[0]));
    cum_sat #(.IN_W(S2W), .OUT_W(O2W), .SHIFT(SH2)) u_sat20i (.val(a_i),  .code(f20_im), .clip(clips[1]));
    cum_sat #(.IN_W(S2W), .OUT_W(O2W), .SHIFT(SH2)) u_sat21  (.val(b_m),  .code(f21),    .clip(clips[2]));
    cum_sat #(.IN_W(CW),  .OUT_W(O4W), .SHIFT(SH4)) u_sat40r (.val(k40r), .code(f40_re), .clip(clips[3]));
    cum_sat #(.IN_W(CW),  .OUT_W(O4W), .SHIFT(SH4)) u_sat40i (.val(k40i), .code(f40_im), .clip(clips[4]));
    cum_sat #(.IN_W(CW),  .OUT_W(O4W), .SHIFT(SH4)) u_sat42  (.val(k42),  .code(f42),    .clip(clips[5]));

    assign any_clip = |clips;
endmodule

// File: rtl/cumulant_window_est.sv
module cumulant_window_est #(
    parameter int DW      = 16,
    parameter int MIN_LOG = 8,
    parameter int MAX_LOG = 12,
    parameter int IN_FRAC = 11,
    parameter int O2W     = 18,
    parameter int F2      = 12,
    parameter int O4W     = 24,
    parameter int F4      = 16,
    parameter int SELW    = $clog2(MAX_LOG-MIN_LOG+1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic [SELW-1:0]       win_sel,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic signed [DW-1:0]  in_i,
    input  logic signed [DW-1:0]  in_q,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic signed [O2W-1:0] c20_re,
    output logic signed [O2W-1:0] c20_im,
    output logic signed [O2W-1:0] c21,
    output logic signed [O4W-1:0] c40_re,
    output logic signed [O4W-1:0] c40_im,
    output logic signed [O4W-1:0] c42,
    output logic                  out_sat
);
    import cum_pkg::*;

    localparam int P2W     = 2*DW+1;
    localparam int P4W     = 2*P2W;
    localparam int S2W     = P2W + MAX_LOG;
    localparam int S4W     = P4W + MAX_LOG;
    localparam int CNTW    = MAX_LOG + 1;
    localparam int LW      = $clog2(MAX_LOG+1);
    localparam int SEL_TOP = MAX_LOG - MIN_LOG;

    cum_state_e state, nxt;

    logic [SELW-1:0]   sel_req, cur_sel;
    logic [LW-1:0]     log_n;
    logic [CNTW-1:0]   win_len, half_len, count;
    logic [MAX_LOG-1:0] n_mask, ptr, half_cnt;
    logic              restart, accept, full, emit;

    logic signed [DW-1:0]  old_i, old_q;
    logic signed [P2W-1:0] n20r, n20i, n21, o20r, o20i, o21;
    logic signed [P4W-1:0] n40r, n40i, n42, o40r, o40i, o42;
    logic signed [P2W-1:0] e20r, e20i, e21;
    logic signed [P4W-1:0] e40r, e40i, e42;
    logic signed [S2W-1:0] s20r, s20i, s21;
    logic signed [S4W-1:0] s40r, s40i, s42;

    logic signed [O2W-1:0] f20r, f20i, f21;
    logic signed [O4W-1:0] f40r, f40i, f42;
    logic                  fclip;

    // window configuration
    assign sel_req  = (win_sel > SELW'(SEL_TOP)) ? SELW'(SEL_TOP) : win_sel;
    assign log_n    = LW'(MIN_LOG) + LW'(cur_sel);
    assign win_len  = CNTW'(1) << log_n;
    assign half_len = win_len >> 1;
    assign n_mask   = MAX_LOG'(win_len - CNTW'(1));
    assign restart  = clr || (sel_req != cur_sel);
    assign accept   = in_valid && in_ready;
    assign full     = (count == win_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_sel <= '0;
        else if (restart) cur_sel <= sel_req;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FILL;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt  = state;
        emit = 1'b0;
        unique case (state)
            ST_FILL: begin
                emit = accept && (count == win_len - CNTW'(1));
                if (emit) nxt = ST_FORM;
            end
            ST_SLIDE: begin
                emit = accept && (half_cnt == MAX_LOG'(half_len - CNTW'(1)));
                if (emit) nxt = ST_FORM;
            end
            ST_FORM: nxt = ST_HOLD;
            ST_HOLD: if (out_ready) nxt = ST_SLIDE;
            default: nxt = ST_FILL;
        endcase
        if (restart) nxt = ST_FILL;
    end

    // handshake outputs
    always_comb begin
        in_ready  = (state == ST_FILL) || (state == ST_SLIDE);
        out_valid = (state == ST_HOLD);
    end

    // sample store, products of arriving and leaving samples
    cum_ring #(.DW(DW), .ADDR_W(MAX_LOG)) u_ring (
        .clk(clk), .wr_en(accept && !restart), .slot(ptr),
        .wr_i(in_i), .wr_q(in_q), .rd_i(old_i), .rd_q(old_q)
    );

    cum_products #(.DW(DW)) u_prod_new (
        .smp_i(in_i), .smp_q(in_q), .sq_re(n20r), .sq_im(n20i), .pw2(n21),
        .qd_re(n40r), .qd_im(n40i), .pw4(n42)
    );

    cum_products #(.DW(DW)) u_prod_old (
        .smp_i(old_i), .smp_q(old_q), .sq_re(o20r), .sq_im(o20i), .pw2(o21),
        .qd_re(o40r), .qd_im(o40i), .pw4(o42)
    );

    always_comb begin
        e20r = full ? o20r : '0;
        e20i = full ? o20i : '0;
        e21  = full ? o21  : '0;
        e40r = full ? o40r : '0;
        e40i = full ? o40i : '0;
        e42  = full ? o42  : '0;
    end

    // moment sums and window bookkeeping, one pass per sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s20r <= '0; s20i <= '0; s21 <= '0;
            s40r <= '0; s40i <= '0; s42 <= '0;
            count <= '0; ptr <= '0; half_cnt <= '0;
        end else if (restart) begin
            s20r <= '0; s20i <= '0; s21 <= '0;
            s40r <= '0; s40i <= '0; s42 <= '0;
            count <= '0; ptr <= '0; half_cnt <= '0;
        end else if (accept) begin
            s20r <= s20r + S2W'(n20r) - S2W'(e20r);
            s20i <= s20i + S2W'(n20i) - S2W'(e20i);
            s21  <= s21  + S2W'(n21)  - S2W'(e21);
            s40r <= s40r + S4W'(n40r) - S4W'(e40r);
            s40i <= s40i + S4W'(n40i) - S4W'(e40i);
            s42  <= s42  + S4W'(n42)  - S4W'(e42);
            ptr  <= (ptr + MAX_LOG'(1)) & n_mask;
            if (!full) count <= count + CNTW'(1);
            if (full) half_cnt <= emit ? '0 : half_cnt + MAX_LOG'(1);
        end
    end

    cum_former #(
        .DW(DW), .MAX_LOG(MAX_LOG), .IN_FRAC(IN_FRAC), .O2W(O2W), .F2(F2),
        .O4W(O4W), .F4(F4), .LW(LW)
    ) u_former (
        .log_n(log_n), .s20_re(s20r), .s20_im(s20i), .s21(s21),
        .s40_re(s40r), .s40_im(s40i), .s42(s42),
        .f20_re(f20r), .f20_im(f20i), .f21(f21),
        .f40_re(f40r), .f40_im(f40i), .f42(f42), .any_clip(fclip)
    );

    // output vector register, loaded in FORM
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c20_re <= '0; c20_im <= '0; c21 <= '0;
            c40_re <= '0; c40_im <= '0; c42 <= '0; out_sat <= 1'b0;
        end else if (state == ST_FORM) begin
            c20_re <= f20r; c20_im <= f20i; c21 <= f21;
            c40_re <= f40r; c40_im <= f40i; c42 <= f42; out_sat <= fclip;
        end
    end

    assert_no_intake_while_offer_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_offer_needs_full_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (count == win_len));

    assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= win_len);

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !restart) |=>
        (out_valid && $stable(c20_re) && $stable(c21) && $stable(c40_im) && $stable(c42) && $stable(out_sat)));

    assert_restart_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0 && !out_valid && s21 == '0));
endmodule

// File: tb/cumulant_window_est_tb.sv
`timescale 1ns/1ps
module cumulant_window_est_tb;
    typedef struct packed {
        logic signed [17:0] c20r, c20i, c21;
        logic signed [23:0] c40r, c40i, c42;
        logic               sat;
    } vec_t;

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
    logic [2:0] win_sel = 3'd0;
    logic in_valid = 1'b0, in_ready, out_valid, out_ready;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic signed [17:0] c20_re, c20_im, c21;
    logic signed [23:0] c40_re, c40_im, c42;
    logic out_sat;

    int tests_run = 0, tests_failed = 0;
    int rdy_mode = 0, cyc = 0, cur_n = 256, acc_cnt = 0;
    logic signed [15:0] hist_i[$], hist_q[$];
    vec_t expq[$];
    vec_t last_v;
    bit   hold_prev = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #2 clk = ~clk;

    cumulant_window_est u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .win_sel(win_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_ready(out_ready),
        .c20_re(c20_re), .c20_im(c20_im), .c21(c21),
        .c40_re(c40_re), .c40_im(c40_im), .c42(c42), .out_sat(out_sat)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic signed [127:0] act, input logic signed [127:0] exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rng(input logic [31:0] s);
        logic [31:0] t = s;
        t ^= t << 13; t ^= t >> 17; t ^= t << 5;
        return t;
    endfunction

    function automatic logic signed [127:0] satw(input logic signed [127:0] v, input int w, inout bit c);
        logic signed [127:0] hi = (128'sd1 <<< (w-1)) - 128'sd1;
        logic signed [127:0] lo = -hi - 128'sd1;
        if (v > hi) begin c = 1; return hi; end
        if (v < lo) begin c = 1; return lo; end
        return v;
    endfunction

    // reference model: batch sums over the last N samples (R4..R8)
    function automatic vec_t model_vec();
        logic signed [127:0] s20r = 0, s20i = 0, s21 = 0, s40r = 0, s40i = 0, s42 = 0;
        logic signed [127:0] ar, ai, b, dr, di, e;
        int L = $clog2(cur_n);
        bit c = 0;
        vec_t v;
        for (int k = 0; k < hist_i.size(); k++) begin
            logic signed [127:0] xi = hist_i[k], xq = hist_q[k];
            logic signed [127:0] a = xi*xi - xq*xq, bb = 2*xi*xq, m = xi*xi + xq*xq;
            s20r += a; s20i += bb; s21 += m;
            s40r += a*a - bb*bb; s40i += 2*a*bb; s42 += m*m;
        end
        ar = s20r >>> L; ai = s20i >>> L; b = s21 >>> L;
        dr = s40r >>> L; di = s40i >>> L; e = s42 >>> L;
        v.c20r = 18'(satw(ar >>> 10, 18, c));
        v.c20i = 18'(satw(ai >>> 10, 18, c));
        v.c21  = 18'(satw(b  >>> 10, 18, c));
        v.c40r = 24'(satw((dr - 3*(ar*ar - ai*ai)) >>> 28, 24, c));
        v.c40i = 24'(satw((di - 6*ar*ai) >>> 28, 24, c));
        v.c42  = 24'(satw((e - ar*ar - ai*ai - 2*b*b) >>> 28, 24, c));
        v.sat  = c;
        return v;
    endfunction

    task automatic model_reset(input int n);
        hist_i.delete(); hist_q.delete(); expq.delete();
        acc_cnt = 0; cur_n = n;
    endtask

    // driver: offers one sample, pushes an expected vector when one is due
    task automatic send(input logic signed [15:0] si, input logic signed [15:0] sq);
        @(negedge clk);
        in_valid = 1'b1; in_i = si; in_q = sq;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
        hist_i.push_back(si); hist_q.push_back(sq);
        if (hist_i.size() > cur_n) begin
            void'(hist_i.pop_front()); void'(hist_q.pop_front());
        end
        acc_cnt++;
        if (acc_cnt == cur_n || (acc_cnt > cur_n && ((acc_cnt - cur_n) % (cur_n/2)) == 0))
            expq.push_back(model_vec());
    endtask

    task automatic send_rand(input int cnt, input int amp);
        for (int k = 0; k < cnt; k++) begin
            seed = rng(seed);
            send(16'(int'($signed(seed[15:0])) % (amp+1)), 16'(int'($signed(seed[31:16])) % (amp+1)));
        end
    endtask

    task automatic send_qpsk(input int cnt, input int amp);
        for (int k = 0; k < cnt; k++) begin
            seed = rng(seed);
            send(seed[3] ? 16'(amp) : 16'(-amp), seed[9] ? 16'(amp) : 16'(-amp));
        end
    endtask

    task automatic drain();
        for (int k = 0; k < 400 && expq.size() != 0; k++) @(negedge clk);
        chk(expq.size() == 0, "R4", "expected vectors left undelivered", expq.size(), 0);
    endtask

    task automatic pulse_clr(input int n);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        model_reset(n);
    endtask

    task automatic set_sel(input logic [2:0] s, input int n);
        @(negedge clk); win_sel = s;
        @(negedge clk); @(negedge clk);
        model_reset(n);
    endtask

    // out_ready pattern, changed just after the active edge
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk); #1;
            cyc++;
            case (rdy_mode)
                0: out_ready = 1'b1;
                1: out_ready = (cyc % 3 == 0);
                default: out_ready = 1'b0;
            endcase
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            vec_t cur;
            cur = '{c20_re, c20_im, c21, c40_re, c40_im, c42, out_sat};
            if (out_valid && in_ready) chk(0, "R1", "in_ready high while vector offered", 1, 0);
            if (hold_prev && out_valid)
                chk(cur == last_v, "R9", "vector changed while stalled", cur.c42, last_v.c42);
            if (out_valid && out_ready) begin
                if (expq.size() == 0) chk(0, "R3", "vector offered when none due", 1, 0);
                else begin
                    vec_t e;
                    e = expq.pop_front();
                    chk(cur.c20r == e.c20r, "R5", "c20_re", cur.c20r, e.c20r);
                    chk(cur.c20i == e.c20i, "R5", "c20_im", cur.c20i, e.c20i);
                    chk(cur.c21  == e.c21,  "R5", "c21",    cur.c21,  e.c21);
                    chk(cur.c40r == e.c40r, "R6", "c40_re", cur.c40r, e.c40r);
                    chk(cur.c40i == e.c40i, "R6", "c40_im", cur.c40i, e.c40i);
                    chk(cur.c42  == e.c42,  "R7", "c42",    cur.c42,  e.c42);
                    chk(cur.sat  == e.sat,  "R8", "out_sat", cur.sat, e.sat);
                end
            end
            hold_prev = out_valid && !out_ready;
            last_v = cur;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests_run++; tests_failed++;
        $display("FAIL R3 watchdog expired: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R11", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R11", "in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);

        // R3, R4, R5..R7: N=256, random samples, output always taken
        model_reset(256);
        send_rand(255, 3000);
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R3", "vector before window full", out_valid, 0);
        send_rand(385, 3000);
        drain();

        // R8: full-scale constant, then the other axis, both clip
        pulse_clr(256);
        for (int k = 0; k < 256; k++) send(16'sd32767, 16'sd0);
        for (int k = 0; k < 128; k++) send(16'sd0, 16'sd32767);
        for (int k = 0; k < 128; k++) send(16'sd0, -16'sd32768);
        drain();

        // R2, R9: N=512 via code 1, four-point symbols, stalled output
        set_sel(3'd1, 512);
        rdy_mode = 1;
        send_qpsk(1024, 2500);
        drain();
        rdy_mode = 0;

        // R2: code 7 is treated as the largest window
        set_sel(3'd7, 4096);
        send_rand(4095, 1500);
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R2", "code 7 window shorter than 4096", out_valid, 0);
        send_rand(2049, 1500);
        drain();

        // R10: clear drops a pending vector and starts a fresh window
        set_sel(3'd0, 256);
        rdy_mode = 2;
        send_rand(256, 2000);
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b1, "R10", "vector pending before clear", out_valid, 1);
        chk(in_ready == 1'b0, "R1", "in_ready while vector pending", in_ready, 0);
        pulse_clr(256);
        chk(out_valid == 1'b0, "R10", "pending vector dropped by clear", out_valid, 0);
        chk(in_ready == 1'b1, "R10", "intake open after clear", in_ready, 1);
        rdy_mode = 0;
        send_qpsk(255, 1800);
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R10", "no vector before fresh window fills", out_valid, 0);
        send_qpsk(1, 1800);
        drain();

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule